// File: doc/BRIEF.md
# Buffered Channel Request Scanner

This block sweeps a ring of eight request sources in a fixed order: three buffered input channels, three buffered output channels, an external interrupt line and a real-time clock tick. Each source owns one slot in the ring. The scanner spends a fixed number of clocks on each slot and then moves to the next one. A full sweep of all eight slots therefore takes a constant time, which is meant to match one memory phase.

When an active channel has its ready flag raised at the end of its slot, the scanner stops. It raises a hold to the main processor, grants that one channel, and presents the channel's current buffer address. It then waits for a single-word service handshake. After the word completes, the scanner releases the processor and continues with the next slot. It never restarts from slot 0, so a busy channel cannot lock out the others.

Each channel is started by an activate command that carries a start address and a terminal address. The address steps after every word. After the word at the terminal address, the channel falls idle and emits a completion pulse. The interrupt slot only latches a pending bit. The clock slot advances a tick counter. Neither of these two slots holds the processor.

Top module: `chan_scanner`

## Requirements
- R1: While reset is asserted, and until the internal reset release completes (two clocks after `rst_n` rises), grant, hold, completion pulses, scan_done, irq_pend and rtc_count are all zero. All channels are idle and the scan stands at slot 0.
- R2: Slots are visited in the fixed order 0..7: slots 0-2 are input channels 0-2, slots 3-5 are output channels 3-5, slot 6 is the interrupt line and slot 7 is the clock tick. Each slot lasts SLOT_CLKS clocks when nothing is serviced.
- R3: If a channel is active and its `chan_flag` bit is high on the last clock of its slot, then from the next clock `hold` is high and `grant` has exactly one bit set, bit i for channel i.
- R4: While granted, `svc_addr` shows the channel's current address and stays stable. On the clock where `svc_done` is high, the address steps by one (modulo 2^ADDR_W), `hold` drops on the next clock, and scanning resumes at the following slot.
- R5: A word serviced while the channel's address equals its terminal address makes the channel idle. Its `cmpl_pulse` bit is high for exactly one clock, the clock after that `svc_done`. The flags of an idle channel are ignored.
- R6: If `irq_line` is high on the last clock of slot 6, `irq_pend` is set. `irq_ack` clears it, and a set in the same clock wins. Slots 6 and 7 never raise `hold`.
- R7: `rtc_tick` pulses are latched. On the last clock of slot 7, a latched tick increments `rtc_count` by one (wrapping) and is consumed. A tick arriving in that same clock stays latched.
- R8: `scan_done` is a one-clock pulse on the clock after slot 7 completes its dwell.
- R9: `act_valid` with `act_chan` 0-5 loads that channel's current and terminal address and makes it active. Values 6 and 7 are ignored. An activate aimed at the channel currently granted is ignored.
- R10: After a channel is serviced, the next slot considered is the following one, even if the serviced channel's flag is still high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_valid | input | 1 | Activate command strobe |
| act_chan | input | 3 | Channel to activate (0-5 valid) |
| act_addr | input | ADDR_W | Initial buffer address |
| act_limit | input | ADDR_W | Terminal buffer address |
| chan_flag | input | 6 | Per-channel ready flags |
| svc_done | input | 1 | One-word service finished |
| irq_line | input | 1 | External interrupt request |
| irq_ack | input | 1 | Clears pending interrupt |
| rtc_tick | input | 1 | Real-time clock tick pulse |
| grant | output | 8 | One-hot slot grant |
| hold | output | 1 | Processor hold during a word transfer |
| svc_addr | output | ADDR_W | Address of the word being serviced |
| cmpl_pulse | output | 6 | Channel finished its buffer |
| irq_pend | output | 1 | Latched interrupt request |
| rtc_count | output | RTC_W | Tick counter |
| scan_done | output | 1 | Sweep completed pulse |

## Verification
The scanner is first driven with every channel active and flagging, and with the handshake returning at once. This exposes the ring order and confirms that a flag still high after service does not win a second turn. A random phase follows, with sparse flags, delayed handshakes, overlapping interrupt and tick activity, and activates to illegal channel numbers. This phase separates correct dwell counting and slot-skipping from a scanner that rescans or misses slots. Short buffers, a buffer that wraps past the top address, and an activate aimed at the granted channel check the completion and ignore rules against a behavioural model.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int NCHAN    = 6;
  localparam int NSLOT    = 8;
  localparam int SLOT_W   = 3;
  localparam int IRQ_SLOT = 6;
  localparam int RTC_SLOT = 7;

  typedef enum logic {
    ST_SCAN  = 1'b0,
    ST_SERVE = 1'b1
  } scan_st_e;
endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import scan_pkg::*;
#(
  parameter int SLOT_CLKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCHAN-1:0]  chan_req,
  input  logic              svc_done,
  output logic [SLOT_W-1:0] slot,
  output logic              serving,
  output logic              slot_end,
  output logic              svc_fin,
  output logic              scan_done
);
  localparam int DW = (SLOT_CLKS > 1) ? $clog2(SLOT_CLKS) : 1;

  scan_st_e          st_q, st_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [DW-1:0]     dwell_q, dwell_d;
  logic              sdone_q, sdone_d;
  logic [NSLOT-1:0]  req_pad;
  logic              dwell_last, take;

  assign req_pad    = {{(NSLOT-NCHAN){1'b0}}, chan_req};
  assign dwell_last = (dwell_q == DW'(SLOT_CLKS-1));
  assign slot_end   = (st_q == ST_SCAN) && dwell_last;
  assign take       = slot_end && req_pad[slot_q];
  assign svc_fin    = (st_q == ST_SERVE) && svc_done;

  always_comb begin
    st_d    = st_q;
    slot_d  = slot_q;
    dwell_d = dwell_q;
    sdone_d = 1'b0;
    case (st_q)
      ST_SCAN: begin
        if (take) begin
          st_d = ST_SERVE;
        end else if (dwell_last) begin
          slot_d  = slot_q + SLOT_W'(1);
          dwell_d = '0;
          sdone_d = (slot_q == SLOT_W'(RTC_SLOT));
        end else begin
          dwell_d = dwell_q + DW'(1);
        end
      end
      default: begin
        if (svc_done) begin
          st_d    = ST_SCAN;
          slot_d  = slot_q + SLOT_W'(1);
          dwell_d = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_SCAN;
      slot_q  <= '0;
      dwell_q <= '0;
      sdone_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      slot_q  <= slot_d;
      dwell_q <= dwell_d;
      sdone_q <= sdone_d;
    end
  end

  assign slot      = slot_q;
  assign serving   = (st_q == ST_SERVE);
  assign scan_done = sdone_q;
endmodule

// File: rtl/chan_regs.sv
module chan_regs
  import scan_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  logic [2:0]        act_chan,
  input  logic [ADDR_W-1:0] act_addr,
  input  logic [ADDR_W-1:0] act_limit,
  input  logic [NCHAN-1:0]  chan_flag,
  input  logic              serving,
  input  logic [SLOT_W-1:0] slot,
  input  logic              svc_fin,
  output logic [NCHAN-1:0]  chan_req,
  output logic [ADDR_W-1:0] svc_addr,
  output logic [NCHAN-1:0]  cmpl_pulse
);
  logic [NCHAN-1:0][ADDR_W-1:0] addr_all;

  for (genvar g = 0; g < NCHAN; g++) begin : g_ch
    logic [ADDR_W-1:0] addr_q, addr_d, lim_q;
    logic              act_q, act_d, cmpl_q, cmpl_d;
    logic              sel, load, fin;

    assign sel  = (slot == SLOT_W'(g));
    assign load = act_valid && (act_chan == 3'(g)) && !(serving && sel);
    assign fin  = svc_fin && sel;

    always_comb begin
      addr_d = addr_q;
      act_d  = act_q;
      cmpl_d = 1'b0;
      if (fin) begin
        if (addr_q == lim_q) begin
          act_d  = 1'b0;
          cmpl_d = 1'b1;
        end else begin
          addr_d = addr_q + ADDR_W'(1);
        end
      end
      if (load) begin
        addr_d = act_addr;
        act_d  = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        addr_q <= '0;
        lim_q  <= '0;
        act_q  <= 1'b0;
        cmpl_q <= 1'b0;
      end else begin
        addr_q <= addr_d;
        act_q  <= act_d;
        cmpl_q <= cmpl_d;
        if (load) lim_q <= act_limit;
      end
    end

    assign addr_all[g]   = addr_q;
    assign chan_req[g]   = act_q && chan_flag[g];
    assign cmpl_pulse[g] = cmpl_q;
  end

  always_comb begin
    svc_addr = '0;
    for (int i = 0; i < NCHAN; i++) begin
      if (serving && (slot == SLOT_W'(i))) svc_addr = addr_all[i];
    end
  end
endmodule

// File: rtl/aux_slots.sv
module aux_slots
  import scan_pkg::*;
#(
  parameter int RTC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic              slot_end,
  input  logic              irq_line,
  input  logic              irq_ack,
  input  logic              rtc_tick,
  output logic              irq_pend,
  output logic [RTC_W-1:0]  rtc_count
);
  logic             irq_q, irq_d, tick_q, tick_d;
  logic [RTC_W-1:0] cnt_q, cnt_d;
  logic             irq_set, rtc_use;

  assign irq_set = slot_end && (slot == SLOT_W'(IRQ_SLOT)) && irq_line;
  assign rtc_use = slot_end && (slot == SLOT_W'(RTC_SLOT)) && tick_q;

  always_comb begin
    irq_d  = irq_q;
    if (irq_ack) irq_d = 1'b0;
    if (irq_set) irq_d = 1'b1;
    tick_d = tick_q | rtc_tick;
    cnt_d  = cnt_q;
    if (rtc_use) begin
      tick_d = rtc_tick;
      cnt_d  = cnt_q + RTC_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      tick_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      irq_q  <= irq_d;
      tick_q <= tick_d;
      cnt_q  <= cnt_d;
    end
  end

  assign irq_pend  = irq_q;
  assign rtc_count = cnt_q;
endmodule

// File: rtl/chan_scanner.sv
module chan_scanner
  import scan_pkg::*;
#(
  parameter int ADDR_W    = 15,
  parameter int SLOT_CLKS = 1,
  parameter int RTC_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_valid,
  input  logic [2:0]        act_chan,
  input  logic [ADDR_W-1:0] act_addr,
  input  logic [ADDR_W-1:0] act_limit,
  input  logic [5:0]        chan_flag,
  input  logic              svc_done,
  input  logic              irq_line,
  input  logic              irq_ack,
  input  logic              rtc_tick,
  output logic [7:0]        grant,
  output logic              hold,
  output logic [ADDR_W-1:0] svc_addr,
  output logic [5:0]        cmpl_pulse,
  output logic              irq_pend,
  output logic [RTC_W-1:0]  rtc_count,
  output logic              scan_done
);
  logic              rs_meta, rs_sync;
  logic [SLOT_W-1:0] slot;
  logic              serving, slot_end, svc_fin;
  logic [NCHAN-1:0]  chan_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end

  scan_seq #(.SLOT_CLKS(SLOT_CLKS)) u_seq (
    .clk       (clk),
    .rst_n     (rs_sync),
    .chan_req  (chan_req),
    .svc_done  (svc_done),
    .slot      (slot),
    .serving   (serving),
    .slot_end  (slot_end),
    .svc_fin   (svc_fin),
    .scan_done (scan_done)
  );

  chan_regs #(.ADDR_W(ADDR_W)) u_chan (
    .clk        (clk),
    .rst_n      (rs_sync),
    .act_valid  (act_valid),
    .act_chan   (act_chan),
    .act_addr   (act_addr),
    .act_limit  (act_limit),
    .chan_flag  (chan_flag),
    .serving    (serving),
    .slot       (slot),
    .svc_fin    (svc_fin),
    .chan_req   (chan_req),
    .svc_addr   (svc_addr),
    .cmpl_pulse (cmpl_pulse)
  );

  aux_slots #(.RTC_W(RTC_W)) u_aux (
    .clk       (clk),
    .rst_n     (rs_sync),
    .slot      (slot),
    .slot_end  (slot_end),
    .irq_line  (irq_line),
    .irq_ack   (irq_ack),
    .rtc_tick  (rtc_tick),
    .irq_pend  (irq_pend),
    .rtc_count (rtc_count)
  );

  always_comb begin
    grant = '0;
    if (serving) grant[slot] = 1'b1;
  end
  assign hold = serving;
endmodule

// File: rtl/scanner_chk.sv
module scanner_chk #(
  parameter int ADDR_W = 15,
  parameter int RTC_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [7:0]        grant,
  input logic              hold,
  input logic              svc_done,
  input logic [ADDR_W-1:0] svc_addr,
  input logic [5:0]        cmpl_pulse,
  input logic [RTC_W-1:0]  rtc_count,
  input logic              scan_done
);
  p_grant_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> ($countones(grant) == 1));

  p_hold_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && svc_done) |=> !hold);

  p_addr_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !svc_done) |=> ($stable(svc_addr) && $stable(grant) && hold));

  p_cmpl_after_svc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_pulse != 6'd0) |-> $past(hold && svc_done));

  p_aux_no_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> (grant[7:6] == 2'b00));

  p_rtc_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_count != $past(rtc_count)) |-> (rtc_count == RTC_W'($past(rtc_count) + 1'b1)));

  p_scan_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |=> !scan_done);
endmodule

bind chan_scanner scanner_chk #(.ADDR_W(ADDR_W), .RTC_W(RTC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .grant      (grant),
  .hold       (hold),
  .svc_done   (svc_done),
  .svc_addr   (svc_addr),
  .cmpl_pulse (cmpl_pulse),
  .rtc_count  (rtc_count),
  .scan_done  (scan_done)
);

// File: tb/chan_scanner_tb.sv
`timescale 1ns/1ps
module chan_scanner_tb;
  localparam int AW = 15;
  localparam int SC = 2;
  localparam int RW = 16;
  localparam int AMOD = 1 << AW;
  localparam int RMOD = 1 << RW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          act_valid;
  logic [2:0]    act_chan;
  logic [AW-1:0] act_addr, act_limit;
  logic [5:0]    chan_flag;
  logic          svc_done, irq_line, irq_ack, rtc_tick;
  logic [7:0]    grant;
  logic          hold;
  logic [AW-1:0] svc_addr;
  logic [5:0]    cmpl_pulse;
  logic          irq_pend;
  logic [RW-1:0] rtc_count;
  logic          scan_done;

  int checks = 0;
  int bad = 0;
  bit chk_on = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  chan_scanner #(.ADDR_W(AW), .SLOT_CLKS(SC), .RTC_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_chan(act_chan),
    .act_addr(act_addr), .act_limit(act_limit), .chan_flag(chan_flag),
    .svc_done(svc_done), .irq_line(irq_line), .irq_ack(irq_ack),
    .rtc_tick(rtc_tick), .grant(grant), .hold(hold), .svc_addr(svc_addr),
    .cmpl_pulse(cmpl_pulse), .irq_pend(irq_pend), .rtc_count(rtc_count),
    .scan_done(scan_done)
  );

  // behavioural reference model
  bit m_serve, m_irq, m_tickp, m_sdone;
  int m_slot, m_dwell, m_rs, m_rtc;
  int m_addr[6];
  int m_lim[6];
  bit m_act[6];
  bit [5:0] m_cmpl;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rs = 0; m_serve = 0; m_slot = 0; m_dwell = 0; m_irq = 0; m_tickp = 0;
      m_rtc = 0; m_cmpl = 0; m_sdone = 0;
      for (int i = 0; i < 6; i++) begin m_addr[i] = 0; m_lim[i] = 0; m_act[i] = 0; end
    end else if (m_rs < 2) begin
      m_rs++;
    end else begin
      bit was_serve;
      bit at_end;
      int cur;
      was_serve = m_serve;
      cur = m_slot;
      at_end = !m_serve && (m_dwell == SC - 1);
      m_cmpl = 0;
      m_sdone = 0;
      if (irq_ack) m_irq = 0;
      if (at_end && cur == 6 && irq_line) m_irq = 1;
      if (at_end && cur == 7 && m_tickp) begin
        m_rtc = (m_rtc + 1) % RMOD;
        m_tickp = rtc_tick;
      end else if (rtc_tick) m_tickp = 1;
      if (m_serve) begin
        if (svc_done) begin
          if (m_addr[cur] == m_lim[cur]) begin m_act[cur] = 0; m_cmpl[cur] = 1; end
          else m_addr[cur] = (m_addr[cur] + 1) % AMOD;
          m_serve = 0; m_slot = (cur + 1) % 8; m_dwell = 0;
        end
      end else if (at_end) begin
        if (cur < 6 && m_act[cur] && chan_flag[cur]) m_serve = 1;
        else begin
          if (cur == 7) m_sdone = 1;
          m_slot = (cur + 1) % 8; m_dwell = 0;
        end
      end else m_dwell++;
      if (act_valid && act_chan < 6 && !(was_serve && cur == int'(act_chan))) begin
        m_addr[act_chan] = int'(act_addr);
        m_lim[act_chan] = int'(act_limit);
        m_act[act_chan] = 1;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R2 R3 R10 grant order", int'(grant), m_serve ? (1 << m_slot) : 0);
      chk("R3 R4 hold", int'(hold), int'(m_serve));
      if (m_serve) chk("R4 R9 svc_addr", int'(svc_addr), m_addr[m_slot]);
      chk("R5 cmpl_pulse", int'(cmpl_pulse), int'(m_cmpl));
      chk("R6 irq_pend", int'(irq_pend), int'(m_irq));
      chk("R7 rtc_count", int'(rtc_count), m_rtc);
      chk("R8 scan_done", int'(scan_done), int'(m_sdone));
    end
  end

  task automatic idle_inputs();
    act_valid = 0; act_chan = 0; act_addr = 0; act_limit = 0; chan_flag = 0;
    svc_done = 0; irq_line = 0; irq_ack = 0; rtc_tick = 0;
  endtask

  task automatic activate(input int ch, input int a, input int l);
    @(negedge clk);
    act_valid = 1; act_chan = 3'(ch); act_addr = AW'(a); act_limit = AW'(l);
    @(negedge clk);
    act_valid = 0;
  endtask

  task automatic finish_run();
    ended = 1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 grant", int'(grant), 0);
    chk("R1 hold", int'(hold), 0);
    chk("R1 rtc_count", int'(rtc_count), 0);
    chk("R1 irq_pend", int'(irq_pend), 0);
    chk("R1 cmpl_pulse", int'(cmpl_pulse), 0);
    chk("R1 scan_done", int'(scan_done), 0);
    rst_n = 1;
    chk_on = 1;
    // R9: load every channel; ch2 wraps past the top address
    activate(0, 100, 103);
    activate(1, 'h40, 'h40);
    activate(2, AMOD - 1, 1);
    activate(3, 10, 20);
    activate(4, 200, 205);
    activate(5, 300, 310);
    activate(7, 5, 5);
    // R10: all flags high, immediate handshake
    for (int c = 0; c < 300; c++) begin
      @(negedge clk);
      chan_flag = 6'h3F; svc_done = 1;
    end
    // R9: activate aimed at the granted channel is ignored
    chan_flag = 0; svc_done = 0;
    activate(4, 0, 40);
    @(negedge clk);
    chan_flag = 6'h10;
    for (int c = 0; c < 40 && !hold; c++) @(negedge clk);
    act_valid = 1; act_chan = 3'd4; act_addr = AW'(999); act_limit = AW'(999);
    @(negedge clk);
    act_valid = 0;
    repeat (2) @(negedge clk);
    svc_done = 1;
    repeat (40) @(negedge clk);
    // random phase
    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      chan_flag = 6'($urandom);
      svc_done  = ($urandom % 3) == 0;
      irq_line  = ($urandom % 4) == 0;
      irq_ack   = ($urandom % 8) == 0;
      rtc_tick  = ($urandom % 3) == 0;
      act_valid = ($urandom % 12) == 0;
      act_chan  = 3'($urandom);
      act_addr  = AW'($urandom);
      act_limit = AW'(int'(act_addr) + int'($urandom % 6));
    end
    idle_inputs();
    repeat (40) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!ended) begin
      bad++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end
endmodule